// File: doc/BRIEF.md
# Serial ADC Interface Responder

This block is the device side of a framed serial converter port, built to run in the system clock domain as a test partner or emulator for a host that reads a 12-bit converter. The host pulls the active-low chip-select down to start a frame, then toggles a serial clock. Both pins are asynchronous to the system clock. Each passes through a two-flop synchronizer and an edge detector, and the frame logic works only from the resulting edge strobes.

When chip-select falls, the block captures a parallel 12-bit two's-complement sample and enters hold. It also starts driving the serial data line, which carries the first of four leading zeros. Each serial-clock falling edge moves the next bit onto the line: first the remaining three zeros, then the sample, most significant bit first. On the rising edge after the thirteenth falling edge, the track/hold signal returns to track. On the sixteenth falling edge, the data line stops being driven.

If chip-select rises before sixteen falling edges have been seen, the frame is abandoned. In that case the line is released, the block returns to track, and a one-cycle abort strobe is raised. Serial-clock edges that arrive after the sixteenth have no effect until a new frame starts. High impedance is shown by a separate enable output, which is low whenever the line should float.

Top module: `adc_serial_responder`

## Requirements
- R1: After reset, `sdataEn` is 0, `holdOut` is 0 and `abortPulse` is 0.
- R2: A falling edge on `csN` captures `sampleIn` and sets `holdOut` to 1 and `sdataEn` to 1. At that point `sdataOut` is 0, which is the first leading zero. Outputs respond within four system clocks of a pin change.
- R3: On the k-th falling edge of `sclk` (k = 1..15), `sdataOut` presents bit 15-k of the 16-bit frame word. Falls 1 to 3 give zeros. Falls 4 to 15 give sample bits 11 down to 0.
- R4: The frame word has bits 15..12 equal to 0 and bits 11..0 equal to the sample captured at the `csN` fall. Changes on `sampleIn` during a frame do not alter the word.
- R5: `holdOut` stays 1 through the first 13 falling edges. It goes to 0 on the `sclk` rising edge that follows the 13th falling edge.
- R6: On the 16th falling edge of `sclk`, `sdataEn` goes to 0.
- R7: If `csN` rises after fewer than 16 falling edges, `sdataEn` and `holdOut` go to 0 and `abortPulse` is 1 for exactly one system clock.
- R8: If `csN` rises after all 16 falling edges, no abort pulse is raised.
- R9: `sclk` edges after the 16th falling edge leave `sdataEn` at 0 and do not cause an abort, until `csN` goes high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Asynchronous active-low chip-select from the host |
| sclk | input | 1 | Asynchronous serial clock from the host |
| sampleIn | input | 12 | Two's-complement sample, captured at chip-select fall |
| sdataOut | output | 1 | Serial data bit (valid while `sdataEn` is 1) |
| sdataEn | output | 1 | Drive enable for the serial data line; 0 means high impedance |
| holdOut | output | 1 | Track/hold control: 1 = hold, 0 = track |
| abortPulse | output | 1 | One-cycle strobe when a frame ends early |

## Verification
Frames use random samples and a random count of serial-clock falling edges, from 1 to 19. Short counts check that aborts appear only when a frame is cut off. Counts of 13 and 14 separate a correct return to track from one that comes one edge early or late. Counts of 16 or more show the release of the data line, and any trailing edges being ignored. Directed frames use the samples 0x800, 0x7FF, 0xFFF and 0x000 with all 16 edges, so that sign-bit and bit-order faults show up in the serialized word. In every frame, `sampleIn` is scrambled after capture, so an output that follows the live input rather than the captured sample is caught.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;
  typedef struct packed {
    logic load;     // capture sample, enter hold, enable line
    logic shift;    // advance serial word
    logic release_; // stop driving line after final bit
    logic track;    // return to track
    logic stop;     // frame closed by chip-select rise
  } ctrlStrobes_t;
endpackage

// File: rtl/adc_resp_sync_edge.sv
module adc_resp_sync_edge #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseOut,
  output logic fallOut
);
  logic [STAGES-1:0] pipeQ;
  logic prevQ;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipeQ <= {STAGES{RESET_VAL}};
        else       pipeQ <= {pipeQ[STAGES-2:0], pinIn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipeQ <= RESET_VAL;
        else       pipeQ <= pinIn;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= RESET_VAL;
    else       prevQ <= pipeQ[STAGES-1];
  end

  assign riseOut = pipeQ[STAGES-1] & ~prevQ;
  assign fallOut = ~pipeQ[STAGES-1] & prevQ;
endmodule

// File: rtl/adc_resp_ctrl.sv
module adc_resp_ctrl
  import adc_resp_pkg::*;
#(
  parameter int FRAME_LEN  = 16,
  parameter int TRACK_EDGE = 13
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csFall,
  input  logic         csRise,
  input  logic         sclkFall,
  input  logic         sclkRise,
  output ctrlStrobes_t strobes,
  output logic         abortPulse
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] TRACK = CNT_W'(TRACK_EDGE);

  logic [CNT_W-1:0] edgeCnt;
  logic activeQ;
  logic abortQ;

  always_comb begin
    strobes          = '0;
    strobes.load     = csFall;
    strobes.shift    = sclkFall && activeQ && (edgeCnt < LAST);
    strobes.release_ = sclkFall && activeQ && (edgeCnt == LAST - 1'b1);
    strobes.track    = sclkRise && activeQ && (edgeCnt >= TRACK);
    strobes.stop     = csRise && activeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      activeQ <= 1'b0;
      abortQ  <= 1'b0;
    end else begin
      abortQ <= csRise && activeQ && (edgeCnt < LAST);
      if (csFall) begin
        edgeCnt <= '0;
        activeQ <= 1'b1;
      end else if (csRise) begin
        edgeCnt <= '0;
        activeQ <= 1'b0;
      end else if (strobes.shift) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

  assign abortPulse = abortQ;

  // R6: the edge count never passes the frame length
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= LAST);
  // R7: abort strobe lasts one cycle
  a_r7_abort_single: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);
  // R9: a finished frame keeps its count while chip-select stays low
  a_r9_hold_done: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == LAST && !csRise && !csFall) |=> edgeCnt == LAST);
  // R3: each accepted falling edge advances the count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (sclkFall && activeQ && edgeCnt < LAST && !csRise && !csFall)
      |=> edgeCnt == $past(edgeCnt) + 1'b1);
endmodule

// File: rtl/adc_resp_datapath.sv
module adc_resp_datapath
  import adc_resp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdataOut,
  output logic              sdataEn,
  output logic              holdOut
);
  localparam int WORD_W = DATA_W + LEAD_W;

  logic [WORD_W-1:0] shReg;
  logic oeQ;
  logic holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      oeQ   <= 1'b0;
      holdQ <= 1'b0;
    end else begin
      if (strobes.load) begin
        shReg <= {{LEAD_W{1'b0}}, sampleIn};
        oeQ   <= 1'b1;
        holdQ <= 1'b1;
      end else begin
        if (strobes.shift)                    shReg <= {shReg[WORD_W-2:0], 1'b0};
        if (strobes.release_ || strobes.stop) oeQ   <= 1'b0;
        if (strobes.track || strobes.stop)    holdQ <= 1'b0;
      end
    end
  end

  assign sdataOut = oeQ & shReg[WORD_W-1];
  assign sdataEn  = oeQ;
  assign holdOut  = holdQ;

  // R6: once released, the line stays quiet until a new frame loads
  a_r6_quiet_after_release: assert property (@(posedge clk) disable iff (!rstN)
    (!oeQ && !strobes.load) |=> !oeQ);
  // R2: a new frame starts driving the first leading zero in hold
  a_r2_frame_start: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (oeQ && holdQ && !sdataOut));
endmodule

// File: rtl/adc_serial_responder.sv
module adc_serial_responder
  import adc_resp_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_W      = 4,
  parameter int TRACK_EDGE  = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdataOut,
  output logic              sdataEn,
  output logic              holdOut,
  output logic              abortPulse
);
  localparam int FRAME_LEN = DATA_W + LEAD_W;

  logic csRise, csFall, sclkRise, sclkFall;
  ctrlStrobes_t strobes;

  adc_resp_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) csSync_i (
    .clk(clk), .rstN(rstN), .pinIn(csN), .riseOut(csRise), .fallOut(csFall));

  adc_resp_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sclkSync_i (
    .clk(clk), .rstN(rstN), .pinIn(sclk), .riseOut(sclkRise), .fallOut(sclkFall));

  adc_resp_ctrl #(.FRAME_LEN(FRAME_LEN), .TRACK_EDGE(TRACK_EDGE)) ctrl_i (
    .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
    .sclkFall(sclkFall), .sclkRise(sclkRise), .strobes(strobes),
    .abortPulse(abortPulse));

  adc_resp_datapath #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleIn(sampleIn),
    .sdataOut(sdataOut), .sdataEn(sdataEn), .holdOut(holdOut));

  // R7: an abort always leaves the line undriven and the block in track
  a_r7_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (!sdataEn && !holdOut));
endmodule

// File: tb/adc_serial_responder_tb.sv
module adc_serial_responder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic [11:0] sampleIn = '0;
  logic sdataOut, sdataEn, holdOut, abortPulse;

  int nTests = 0;
  int nFail = 0;
  int abortCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_serial_responder dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleIn(sampleIn),
    .sdataOut(sdataOut), .sdataEn(sdataEn), .holdOut(holdOut),
    .abortPulse(abortPulse));

  always @(posedge clk) if (abortPulse) abortCount <= abortCount + 1;

  function automatic logic [15:0] expWord(input logic [11:0] s);
    return {4'b0000, s};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic runFrame(input logic [11:0] smp, input int nFalls, input int extra);
    logic [15:0] w;
    int abBefore;
    w = expWord(smp);
    sampleIn = smp;
    @(negedge clk);
    csN = 1'b0;
    settle();
    check(sdataEn == 1'b1, "R2 enable", sdataEn, 1);
    check(holdOut == 1'b1, "R2 hold", holdOut, 1);
    check(sdataOut == 1'b0, "R2 first zero", sdataOut, 0);
    sampleIn = 12'($urandom); // R4: later input changes must not matter
    for (int i = 1; i <= nFalls; i++) begin
      sclk = 1'b0;
      settle();
      if (i < 16) begin
        check(sdataEn == 1'b1, "R3 enable mid frame", sdataEn, 1);
        check(sdataOut == w[15-i], "R3/R4 bit", sdataOut, int'(w[15-i]));
      end
      if (i == 16) check(sdataEn == 1'b0, "R6 release", sdataEn, 0);
      if (i <= 13) check(holdOut == 1'b1, "R5 hold before rise", holdOut, 1);
      sclk = 1'b1;
      settle();
      check(holdOut == (i < 13), "R5 track edge", holdOut, int'(i < 13));
    end
    for (int j = 0; j < extra; j++) begin
      sclk = 1'b0;
      settle();
      check(sdataEn == 1'b0, "R9 ignored fall", sdataEn, 0);
      sclk = 1'b1;
      settle();
      check(sdataEn == 1'b0, "R9 ignored rise", sdataEn, 0);
    end
    abBefore = abortCount;
    csN = 1'b1;
    settle();
    check((abortCount - abBefore) == (nFalls < 16 ? 1 : 0),
          nFalls < 16 ? "R7 abort pulse" : "R8/R9 no abort",
          abortCount - abBefore, nFalls < 16 ? 1 : 0);
    check(sdataEn == 1'b0, "R7 line off after cs", sdataEn, 0);
    check(holdOut == 1'b0, "R7 track after cs", holdOut, 0);
    settle();
  endtask

  initial begin
    int nf;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(sdataEn == 1'b0, "R1 enable", sdataEn, 0);
    check(holdOut == 1'b0, "R1 hold", holdOut, 0);
    check(abortPulse == 1'b0, "R1 abort", abortPulse, 0);
    rstN = 1'b1;
    settle();
    check(sdataEn == 1'b0 && holdOut == 1'b0, "R1 idle after reset", sdataEn, 0);
    runFrame(12'h800, 16, 0);
    runFrame(12'h7FF, 16, 0);
    runFrame(12'hFFF, 16, 3);
    runFrame(12'h000, 16, 0);
    runFrame(12'hA5C, 13, 0);
    runFrame(12'h3C1, 14, 0);
    runFrame(12'h123, 1, 0);
    for (int k = 0; k < 24; k++) begin
      nf = 1 + int'($urandom % 19);
      if (nf > 16) runFrame(12'($urandom), 16, nf - 16);
      else         runFrame(12'($urandom), nf, 0);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule